// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns single write requests into pin-level write cycles for an asynchronous static RAM. In these cycles the write-enable strobe bounds the write. A request carries an address and a data word and is taken on a valid/ready handshake. The sequencer then runs a fixed sequence of phases and drives chip-enable, write-enable, output-enable, the address bus, the data word and the enable of the data-bus driver. All of these leave the block straight from flip-flops.

Every timing limit is given in picoseconds as a parameter. Each one is turned into a whole number of clock cycles at elaboration time: the limit is divided by the clock period, rounded up, and never allowed below one cycle. A parameter picks how output-enable behaves during a write:
- **Output-enable held low:** the memory's own output has to float before the driver may turn on, and the longer write pulse applies.
- **Output-enable held high:** the data can be driven from the start of the cycle, and the shorter pulse applies.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, chip-enable, write-enable and output-enable are high (inactive), the data-bus driver enable is low, and ready is high.
- R2: Ready is high only while the sequencer is idle, and never while chip-enable or write-enable is low. A request is taken at a clock edge where valid and ready are both high. Every request taken produces exactly one write, in order, carrying the request's address and data.
- R3: The address stays constant for as long as chip-enable is low. Chip-enable falls at least ceil(T_SA/T_CLK) cycles (at least one) before write-enable falls.
- R4: Write-enable is low only while chip-enable is low. Each write-enable low pulse lasts at least ceil(T_PWE/T_CLK) cycles. T_PWE is the output-enable-low pulse limit when output-enable is held low during writes, and the output-enable-high limit otherwise.
- R5: Chip-enable has been low for at least ceil(max(T_AW, T_SCE)/T_CLK) cycles when write-enable rises.
- R6: When write-enable rises, the data-bus driver is on with the request's data. The driver has been on for at least ceil(T_SD/T_CLK) cycles at that point, and it stays on for at least ceil(T_HD/T_CLK) cycles (at least one) afterwards.
- R7: With output-enable held low during writes, output-enable is low while write-enable is low and high when write-enable rises. The driver stays off on the cycle write-enable falls and for at least ceil(T_HZWE/T_CLK) cycles after that.
- R8: Chip-enable rises no sooner than ceil(T_HA/T_CLK) cycles (at least one) after write-enable rises.
- R9: Successive falling edges of write-enable are at least ceil(T_WC/T_CLK) cycles apart, including for requests issued back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| sram_ce_n | output | 1 | Chip-enable, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_addr | output | ADDR_W | Address bus |
| sram_dq_o | output | DATA_W | Data to drive on the shared bus |
| sram_dq_oe | output | 1 | Data-bus driver enable |

## Verification
A phase counter that is wrong shows up within the write it corrupts. A strobe that ends early shortens the measured write-enable low time, the chip-enable lead or the data setup. A recovery that is too short brings the next write-enable fall too close to the previous one. A state that gets lost usually strands ready low, so the remaining requests never reach a write and the write-order check fails. In the output-enable-low variant, an early driver enable shows on the very cycle after write-enable falls as a violation of the float window.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_REC    = 3'd4
   } phase_t;

   // ceiling of ps / clock period, never below one cycle
   function automatic int ps_to_cyc(input int ps, input int clk_ps);
      int c;
      c = (ps <= 0) ? 0 : (ps + clk_ps - 1) / clk_ps;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_wr_timer.sv
module sram_wr_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             zero
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sram_wr_pins.sv
module sram_wr_pins #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 8,
   parameter bit OE_LOW_WR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              ev_we_fall,
   input  logic              ev_drv_on,
   input  logic              ev_we_rise,
   input  logic              ev_bus_rel,
   output logic              ce_n,
   output logic              we_n,
   output logic              oe_n,
   output logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_oe
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_n <= 1'b1;
         we_n <= 1'b1;
         addr <= '0;
         dq_o <= '0;
      end else begin
         if (take) begin
            ce_n <= 1'b0;
            addr <= addr_in;
            dq_o <= data_in;
         end
         if (ev_we_fall) we_n <= 1'b0;
         if (ev_we_rise) we_n <= 1'b1;
         if (ev_bus_rel) ce_n <= 1'b1;
      end
   end

   generate
      if (OE_LOW_WR) begin : g_oe_low
         // memory output must float first: driver waits for ev_drv_on
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               oe_n  <= 1'b1;
               dq_oe <= 1'b0;
            end else begin
               if (take)            oe_n  <= 1'b0;
               else if (ev_we_rise) oe_n  <= 1'b1;
               if (ev_drv_on)       dq_oe <= 1'b1;
               else if (ev_bus_rel) dq_oe <= 1'b0;
            end
         end
         a_r7_off_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(we_n) |-> (!dq_oe && !oe_n));
      end else begin : g_oe_high
         // memory output never enabled: drive data from the first phase
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               oe_n  <= 1'b1;
               dq_oe <= 1'b0;
            end else begin
               oe_n <= 1'b1;
               if (take)            dq_oe <= 1'b1;
               else if (ev_bus_rel) dq_oe <= 1'b0;
            end
         end
      end
   endgenerate

   a_r4_we_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);
   a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!ce_n) && !ce_n) |-> $stable(addr));
   a_r6_drv_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> dq_oe);
   a_r8_ce_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ce_n) |-> $past(we_n));
endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
   import sram_wr_pkg::*;
#(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int CLK_PS     = 8000,
   parameter bit OE_LOW_WR  = 1'b1,
   parameter int T_WC_PS    = 10000,
   parameter int T_SCE_PS   = 9000,
   parameter int T_AW_PS    = 9000,
   parameter int T_SA_PS    = 0,
   parameter int T_HA_PS    = 0,
   parameter int T_PWE_OELO = 8000,
   parameter int T_PWE_OEHI = 6500,
   parameter int T_SD_PS    = 7000,
   parameter int T_HD_PS    = 0,
   parameter int T_HZWE_PS  = 6000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              sram_ce_n,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic [ADDR_W-1:0] sram_addr,
   output logic [DATA_W-1:0] sram_dq_o,
   output logic              sram_dq_oe
);
   localparam int N_SA   = ps_to_cyc(T_SA_PS, CLK_PS);
   localparam int N_HA   = ps_to_cyc(T_HA_PS, CLK_PS);
   localparam int N_AW   = ps_to_cyc(T_AW_PS, CLK_PS);
   localparam int N_SCE  = ps_to_cyc(T_SCE_PS, CLK_PS);
   localparam int N_PWE  = ps_to_cyc(OE_LOW_WR ? T_PWE_OELO : T_PWE_OEHI, CLK_PS);
   localparam int N_SD   = ps_to_cyc(T_SD_PS, CLK_PS);
   localparam int N_HD   = ps_to_cyc(T_HD_PS, CLK_PS);
   localparam int N_HZ   = ps_to_cyc(T_HZWE_PS, CLK_PS);
   localparam int N_WC   = ps_to_cyc(T_WC_PS, CLK_PS);
   localparam int N_SU   = N_SA;
   localparam int N_ST_A = imax(N_PWE, imax(N_AW - N_SU, N_SCE - N_SU));
   localparam int N_ST   = imax(N_ST_A, OE_LOW_WR ? (N_HZ + N_SD) : N_SD);
   localparam int N_HOLD = imax(N_HD, N_HA);
   localparam int N_REC  = imax(1, N_WC - (N_SU + N_ST + N_HOLD + 1));
   localparam int N_MAX  = imax(imax(N_SU, N_ST), imax(N_HOLD, N_REC));

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("sram_wr_seq: widths must be positive");
   end
   if (CLK_PS < 1) begin : g_bad_clk
      $error("sram_wr_seq: clock period must be positive");
   end
   if (N_MAX > (2 ** CNT_W) - 1) begin : g_bad_cnt
      $error("sram_wr_seq: CNT_W too narrow for derived counts");
   end

   phase_t           ph, ph_nx;
   logic             t_load, t_zero;
   logic [CNT_W-1:0] t_val, t_cnt;
   logic             take, ev_we_fall, ev_drv_on, ev_we_rise, ev_bus_rel;

   assign req_ready = (ph == PH_IDLE);
   assign take      = req_valid && req_ready;

   always_comb begin
      ph_nx      = ph;
      t_load     = 1'b0;
      t_val      = '0;
      ev_we_fall = 1'b0;
      ev_drv_on  = 1'b0;
      ev_we_rise = 1'b0;
      ev_bus_rel = 1'b0;
      case (ph)
         PH_IDLE: if (take) begin
            ph_nx  = PH_SETUP;
            t_load = 1'b1;
            t_val  = CNT_W'(N_SU - 1);
         end
         PH_SETUP: if (t_zero) begin
            ph_nx      = PH_STROBE;
            t_load     = 1'b1;
            t_val      = CNT_W'(N_ST - 1);
            ev_we_fall = 1'b1;
         end
         PH_STROBE: begin
            ev_drv_on = (t_cnt == CNT_W'(N_ST - N_HZ));
            if (t_zero) begin
               ph_nx      = PH_HOLD;
               t_load     = 1'b1;
               t_val      = CNT_W'(N_HOLD - 1);
               ev_we_rise = 1'b1;
            end
         end
         PH_HOLD: if (t_zero) begin
            ph_nx      = PH_REC;
            t_load     = 1'b1;
            t_val      = CNT_W'(N_REC - 1);
            ev_bus_rel = 1'b1;
         end
         PH_REC: if (t_zero) ph_nx = PH_IDLE;
         default: ph_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= PH_IDLE;
      else        ph <= ph_nx;
   end

   sram_wr_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
      .cnt(t_cnt), .zero(t_zero)
   );

   sram_wr_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OE_LOW_WR(OE_LOW_WR)) u_pins (
      .clk(clk), .rst_n(rst_n), .take(take), .addr_in(req_addr),
      .data_in(req_data), .ev_we_fall(ev_we_fall), .ev_drv_on(ev_drv_on),
      .ev_we_rise(ev_we_rise), .ev_bus_rel(ev_bus_rel),
      .ce_n(sram_ce_n), .we_n(sram_we_n), .oe_n(sram_oe_n),
      .addr(sram_addr), .dq_o(sram_dq_o), .dq_oe(sram_dq_oe)
   );

   a_r2_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce_n && sram_we_n));
   a_r3_ce_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> $past(!sram_ce_n));
   a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !req_ready);
endmodule

// File: tb/sram_wr_seq_bench.sv
module sram_wr_seq_bench;
   localparam int AW = 15;
   localparam int DW = 8;
   localparam int CLK_PS = 8000;
   localparam bit OE_LOW = 1'b1;

   function automatic int cyc(input int ps);
      int c;
      c = (ps <= 0) ? 0 : (ps + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction

   localparam int E_SA  = cyc(0);
   localparam int E_HA  = cyc(0);
   localparam int E_CEW = (cyc(9000) > cyc(9000)) ? cyc(9000) : cyc(9000);
   localparam int E_PWE = OE_LOW ? cyc(8000) : cyc(6500);
   localparam int E_SD  = cyc(7000);
   localparam int E_HD  = cyc(0);
   localparam int E_HZ  = cyc(6000);
   localparam int E_WC  = cyc(10000);

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic ce_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_dq;

   always #4 clk = ~clk;

   sram_wr_seq u_sram_wr_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_data(req_data), .sram_ce_n(ce_n),
      .sram_we_n(we_n), .sram_oe_n(oe_n), .sram_addr(s_addr),
      .sram_dq_o(s_dq), .sram_dq_oe(dq_oe)
   );

   int n_chk = 0, n_bad = 0;
   logic [AW-1:0] qa[$];
   logic [DW-1:0] qd[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor state
   int  now = 0, ce_fall_t = 0, we_fall_t = 0, we_rise_t = 0, drv_t = 0;
   bit  have_fall = 0, mon_on = 0;
   logic p_ce = 1'b1, p_we = 1'b1, p_drv = 1'b0;
   logic [AW-1:0] addr_hold = '0;

   always @(negedge clk) begin
      if (mon_on) begin
         now++;
         if (req_ready) chk(ce_n && we_n, "R2 ready while busy", {ce_n, we_n}, 3);
         if (!we_n) chk(!ce_n, "R4 we low outside ce", ce_n, 0);
         if (!ce_n && p_ce) begin
            ce_fall_t = now;
            addr_hold = s_addr;
         end else if (!ce_n) begin
            chk(s_addr == addr_hold, "R3 address moved", s_addr, addr_hold);
         end
         if (!we_n && p_we) begin
            chk(now - ce_fall_t >= E_SA, "R3 ce lead before we fall", now - ce_fall_t, E_SA);
            if (have_fall)
               chk(now - we_fall_t >= E_WC, "R9 write spacing", now - we_fall_t, E_WC);
            we_fall_t = now;
            have_fall = 1;
            if (OE_LOW) chk(!oe_n && !dq_oe, "R7 oe/driver at we fall", {oe_n, dq_oe}, 0);
         end
         if (dq_oe && !p_drv) begin
            drv_t = now;
            if (OE_LOW) chk(now - we_fall_t >= E_HZ, "R7 driver float wait", now - we_fall_t, E_HZ);
         end
         if (we_n && !p_we) begin
            chk(now - we_fall_t >= E_PWE, "R4 we pulse width", now - we_fall_t, E_PWE);
            chk(now - ce_fall_t >= E_CEW, "R5 ce/addr before write end", now - ce_fall_t, E_CEW);
            chk(dq_oe && (now - drv_t >= E_SD), "R6 data setup", dq_oe ? now - drv_t : -1, E_SD);
            if (qa.size() == 0) begin
               chk(1'b0, "R2 unexpected write", s_addr, -1);
            end else begin
               logic [AW-1:0] ea;
               logic [DW-1:0] ed;
               ea = qa.pop_front();
               ed = qd.pop_front();
               chk(s_addr == ea, "R2 write address", s_addr, ea);
               chk(s_dq == ed, "R2 write data", s_dq, ed);
            end
            if (OE_LOW) chk(oe_n, "R7 oe high after write", oe_n, 1);
            we_rise_t = now;
         end
         if (!dq_oe && p_drv) chk(now - we_rise_t >= E_HD, "R6 data hold", now - we_rise_t, E_HD);
         if (ce_n && !p_ce) chk(now - we_rise_t >= E_HA, "R8 address hold", now - we_rise_t, E_HA);
         p_ce = ce_n; p_we = we_n; p_drv = dq_oe;
      end
   end

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_data  = d;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      qa.push_back(a);
      qd.push_back(d);
      #1;
      req_valid = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1234);
      repeat (3) @(negedge clk);
      chk(ce_n && we_n && oe_n && !dq_oe, "R1 pins under reset", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ce_n && we_n && oe_n && !dq_oe, "R1 pins after reset", {ce_n, we_n, oe_n, dq_oe}, 4'b1110);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      mon_on = 1;
      // directed corners: extreme addresses and data, back to back (R9)
      send('0, '0);
      send({AW{1'b1}}, {DW{1'b1}});
      send(15'h2AAA, 8'h55);
      send(15'h5555, 8'hAA);
      // random mix with gaps
      for (int i = 0; i < 60; i++) begin
         int gap;
         gap = $urandom_range(0, 4);
         repeat (gap) @(negedge clk);
         send(AW'($urandom), DW'($urandom));
      end
      repeat (20) @(negedge clk);
      chk(qa.size() == 0, "R2 all requests written", qa.size(), 0);
      chk(req_ready && ce_n && we_n && !dq_oe, "R2 idle at end", {req_ready, ce_n, we_n, dq_oe}, 4'b1110);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule